// File: doc/BRIEF.md
# Per-Core Countdown Timer with Interrupt Acknowledge

The block is a countdown timer as found next to each processor core's interrupt controller. Software reaches it through a plain 32-bit register port at fixed word offsets. The port gives access to a controller enable with a spare vector, a timer vector entry, a divider code, a start value, a live count and an acknowledge register. Writing the start value arms the countdown. The count then falls by one on each tick of a prescaled clock. When it runs out, the block raises a level interrupt request that carries the timer's vector.

The timer runs either once or repeatedly. A pending flag stays set until software writes zero to the acknowledge register. If a second expiry arrives while the flag is still set, it is remembered and raised again right after the acknowledge. The register port is a single-cycle access path with no handshake. Writes take effect at the clock edge on which `reg_wr` is high. Read data depends only on `reg_addr`, so it is valid in the same cycle.

Top module: `lapic_tmr`

## Requirements
- R1: After reset, every register reads back its reset value. The timer vector entry reads 0x0001_0000, so the mask is set. The enable register reads 0x0000_00FF. The live count, the start value and the divider code read 0. `irq_req` is low.
- R2: The divider register at offset 0x3E0 holds a 3-bit code formed from {bit 3, bit 1, bit 0}. Codes 0 to 6 divide by 2^(code+1), so a value of 3 divides by 16. Code 7 (register value 0xB) divides by 1.
- R3: A write of a nonzero N to the start register at 0x380 loads the live count at 0x390 with N and restarts the prescaler. With a divide ratio D, the count falls once every D cycles. The expiry lands on the N*D-th clock edge after the write.
- R4: In one-shot mode (bits 18:17 of the vector entry at 0x320 equal 00, or any value other than 01), the live count holds at 0 after expiry. No further expiry follows until the next start write.
- R5: In periodic mode (bits 18:17 = 01), the live count reloads from the start value on the expiry edge and keeps counting.
- R6: Writing 0 to the start register stops the timer at once. The live count reads 0 and no expiry follows.
- R7: A write of 0 to offset 0x0B0 clears the pending flag, which drops `irq_req` on that edge. A write of any nonzero value there has no effect. The register reads as 0.
- R8: An expiry that arrives while the flag is pending is held. This includes an expiry on the same edge as the acknowledge. The flag sets again one cycle after it clears, so `irq_req` is low for exactly one cycle.
- R9: While bit 16 of the vector entry is set, expiries are discarded. Clearing the mask later raises no request.
- R10: While bit 8 of the enable register at 0x0F0 is 0, `irq_req` stays low and expiries are discarded. A flag already pending is kept and shows again once the block is re-enabled.
- R11: `irq_vector` equals bits 7:0 of the timer vector entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Level interrupt request |
| irq_vector | output | 8 | Vector of the timer interrupt |

## Verification
Two events can fall on the same clock edge: the acknowledge write and a periodic expiry. The bench arms a periodic count of 4 and lets the first expiry pend. It then times the acknowledge write so that it lands exactly on the second expiry edge. The test passes only if `irq_req` drops for that one cycle and returns on the next. The bench then stops the timer and checks that nothing more is raised, which shows that exactly one held expiry was kept.

// File: rtl/lapic_tmr_pkg.sv
package lapic_tmr_pkg;

  localparam int OFS_EOI  = 'h0B0;
  localparam int OFS_SVR  = 'h0F0;
  localparam int OFS_LVT  = 'h320;
  localparam int OFS_INIT = 'h380;
  localparam int OFS_CUR  = 'h390;
  localparam int OFS_DIV  = 'h3E0;

  // widest prescaler shift is 7 (divide by 128)
  localparam int PRE_W = 7;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_RSV2   = 2'b10,
    MODE_RSV3   = 2'b11
  } tmr_mode_e;

  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'd7) ? 3'd0 : code + 3'd1;
  endfunction

endpackage

// File: rtl/lapic_tmr_regs.sv
module lapic_tmr_regs
  import lapic_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [31:0]       rdata,
  output logic              sw_en,
  output logic [7:0]        lvt_vec,
  output logic              lvt_mask,
  output logic              periodic,
  output logic [2:0]        div_code,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  init_val,
  output logic              eoi
);

  logic [7:0] spur_vec;
  tmr_mode_e  lvt_mode;

  logic hit_svr, hit_lvt, hit_div;
  assign hit_svr = wr && (addr == ADDR_W'(OFS_SVR));
  assign hit_lvt = wr && (addr == ADDR_W'(OFS_LVT));
  assign hit_div = wr && (addr == ADDR_W'(OFS_DIV));
  assign load     = wr && (addr == ADDR_W'(OFS_INIT));
  assign load_val = wdata[CNT_W-1:0];
  assign eoi      = wr && (addr == ADDR_W'(OFS_EOI)) && (wdata == 32'd0);
  assign periodic = (lvt_mode == MODE_REPEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en    <= 1'b0;
      spur_vec <= 8'hFF;
      lvt_vec  <= 8'h00;
      lvt_mask <= 1'b1;
      lvt_mode <= MODE_ONCE;
      div_code <= 3'd0;
      init_val <= '0;
    end else begin
      if (hit_svr) begin
        sw_en    <= wdata[8];
        spur_vec <= wdata[7:0];
      end
      if (hit_lvt) begin
        lvt_vec  <= wdata[7:0];
        lvt_mask <= wdata[16];
        lvt_mode <= tmr_mode_e'(wdata[18:17]);
      end
      if (hit_div) div_code <= {wdata[3], wdata[1:0]};
      if (load)    init_val <= load_val;
    end
  end

  always_comb begin
    rdata = 32'd0;
    case (addr)
      ADDR_W'(OFS_SVR):  rdata = {23'd0, sw_en, spur_vec};
      ADDR_W'(OFS_LVT):  rdata = {13'd0, lvt_mode, lvt_mask, 8'd0, lvt_vec};
      ADDR_W'(OFS_INIT): rdata = 32'(init_val);
      ADDR_W'(OFS_CUR):  rdata = 32'(cur_cnt);
      ADDR_W'(OFS_DIV):  rdata = {28'd0, div_code[2], 1'b0, div_code[1:0]};
      default:           rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/lapic_tmr_prescale.sv
module lapic_tmr_prescale
  import lapic_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] div_code,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] sel_mask;
  logic [2:0]       shift;

  assign shift = div_shift(div_code);

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign sel_mask[i] = (i < int'(shift));
    end
  endgenerate

  assign tick = ((pcnt & sel_mask) == sel_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/lapic_tmr_count.sv
module lapic_tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = running && tick && (cur == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= (load_val != '0);
    end else if (expire) begin
      if (periodic) begin
        cur <= init_val;
      end else begin
        cur     <= '0;
        running <= 1'b0;
      end
    end else if (running && tick) begin
      cur <= cur - ONE;
    end
  end

endmodule

// File: rtl/lapic_tmr_irq.sv
module lapic_tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic sw_en,
  input  logic lvt_mask,
  input  logic eoi,
  output logic pend,
  output logic held,
  output logic irq_req
);

  logic accept;
  assign accept  = expire && sw_en && !lvt_mask;
  assign irq_req = pend && sw_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      held <= 1'b0;
    end else if (pend) begin
      pend <= !eoi;
      held <= held || accept;
    end else begin
      pend <= held || accept;
      held <= 1'b0;
    end
  end

endmodule

// File: rtl/lapic_tmr.sv
module lapic_tmr
  import lapic_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_req,
  output logic [7:0]        irq_vector
);

  logic             sw_en, lvt_mask, periodic, load, eoi;
  logic [2:0]       div_code;
  logic [CNT_W-1:0] load_val, init_val, cur_cnt;
  logic             tick, running, expire, irq_pend, irq_held;

  lapic_tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cur_cnt(cur_cnt), .rdata(reg_rdata), .sw_en(sw_en), .lvt_vec(irq_vector),
    .lvt_mask(lvt_mask), .periodic(periodic), .div_code(div_code), .load(load),
    .load_val(load_val), .init_val(init_val), .eoi(eoi)
  );

  lapic_tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .div_code(div_code), .tick(tick)
  );

  lapic_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .init_val(init_val), .tick(tick), .periodic(periodic), .cur(cur_cnt),
    .running(running), .expire(expire)
  );

  lapic_tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .sw_en(sw_en),
    .lvt_mask(lvt_mask), .eoi(eoi), .pend(irq_pend), .held(irq_held),
    .irq_req(irq_req)
  );

endmodule

// File: rtl/lapic_tmr_chk.sv
module lapic_tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_en,
  input logic             irq_req,
  input logic             lvt_mask,
  input logic             pend,
  input logic             held,
  input logic             eoi,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic             running,
  input logic [CNT_W-1:0] cur
);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> !irq_req);

  p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && pend) |=> !pend);

  p_reraise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && held) |=> pend);

  p_zero_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!running && cur == '0));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(cur));

  p_mask_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvt_mask && !pend && !held) |=> !pend);

endmodule

bind lapic_tmr lapic_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .irq_req(irq_req),
  .lvt_mask(lvt_mask), .pend(irq_pend), .held(irq_held), .eoi(eoi),
  .load(load), .load_val(load_val), .running(running), .cur(cur_cnt)
);

// File: tb/lapic_tmr_test.sv
module lapic_tmr_test;

  localparam logic [11:0] A_EOI = 12'h0B0, A_SVR = 12'h0F0, A_LVT = 12'h320,
                          A_INIT = 12'h380, A_CUR = 12'h390, A_DIV = 12'h3E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lapic_tmr uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_LVT, v);  chk("R1 lvt reset", v, 32'h0001_0000);
    rd(A_SVR, v);  chk("R1 svr reset", v, 32'h0000_00FF);
    rd(A_CUR, v);  chk("R1 cur reset", v, 0);
    rd(A_INIT, v); chk("R1 init reset", v, 0);
    rd(A_DIV, v);  chk("R1 div reset", v, 0);
    chk("R1 irq reset", irq_req, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(A_SVR, 32'h1FF); wr(A_LVT, 32'h40); wr(A_DIV, 32'hB);
    wr(A_INIT, 5);
    rd(A_CUR, v); chk("R3 load", v, 5);
    edges(4); rd(A_CUR, v); chk("R3 count", v, 1); chk("R3 no early irq", irq_req, 0);
    edges(1); chk("R3 expiry", irq_req, 1); chk("R11 vector", irq_vector, 8'h40);
    rd(A_CUR, v); chk("R4 zero", v, 0);
    edges(6); rd(A_CUR, v); chk("R4 holds zero", v, 0);
    wr(A_EOI, 0); chk("R7 eoi clears", irq_req, 0);
    edges(8); chk("R4 no refire", irq_req, 0);
  endtask

  task automatic t_eoi_nonzero;
    logic [31:0] v;
    wr(A_INIT, 2); edges(2); chk("R3 expiry n2", irq_req, 1);
    wr(A_EOI, 1); chk("R7 nonzero ignored", irq_req, 1);
    rd(A_EOI, v); chk("R7 reads zero", v, 0);
    wr(A_EOI, 0); chk("R7 eoi clears", irq_req, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(A_LVT, 32'h0002_0041);
    wr(A_INIT, 3); edges(3);
    chk("R5 first expiry", irq_req, 1); chk("R11 vector", irq_vector, 8'h41);
    rd(A_CUR, v); chk("R5 reload", v, 3);
    wr(A_EOI, 0); chk("R7 ack", irq_req, 0);
    rd(A_CUR, v); chk("R5 keeps counting", v, 2);
    edges(2); chk("R5 second expiry", irq_req, 1);
    wr(A_INIT, 0); wr(A_EOI, 0);
  endtask

  task automatic t_collide;
    wr(A_INIT, 4); edges(4);
    chk("R8 first expiry", irq_req, 1);
    edges(3);
    wr(A_EOI, 0);
    chk("R8 drop one cycle", irq_req, 0);
    edges(1); chk("R8 reraised", irq_req, 1);
    wr(A_INIT, 0); wr(A_EOI, 0);
    chk("R8 cleared", irq_req, 0);
    edges(3); chk("R8 single held", irq_req, 0);
  endtask

  task automatic t_divide;
    logic [31:0] v;
    wr(A_LVT, 32'h40); wr(A_DIV, 3);
    rd(A_DIV, v); chk("R2 div readback", v, 3);
    wr(A_INIT, 2); edges(31);
    chk("R2 div16 not yet", irq_req, 0);
    rd(A_CUR, v); chk("R2 div16 count", v, 1);
    edges(1); chk("R2 div16 expiry", irq_req, 1);
    wr(A_EOI, 0);
    wr(A_DIV, 0); wr(A_INIT, 3); edges(5);
    chk("R2 div2 not yet", irq_req, 0);
    edges(1); chk("R2 div2 expiry", irq_req, 1);
    wr(A_EOI, 0); wr(A_DIV, 32'hB);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(A_INIT, 10); edges(2);
    rd(A_CUR, v); chk("R6 counting", v, 8);
    wr(A_INIT, 0);
    rd(A_CUR, v); chk("R6 stopped", v, 0);
    edges(20); chk("R6 no irq", irq_req, 0);
    rd(A_CUR, v); chk("R6 stays zero", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(A_LVT, 32'h0001_0040); wr(A_INIT, 2); edges(4);
    chk("R9 masked", irq_req, 0);
    rd(A_CUR, v); chk("R9 expired", v, 0);
    wr(A_LVT, 32'h40); edges(2);
    chk("R9 dropped", irq_req, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wr(A_SVR, 32'h0FF); wr(A_INIT, 2); edges(3);
    chk("R10 off quiet", irq_req, 0);
    rd(A_SVR, v); chk("R10 svr", v, 32'hFF);
    wr(A_SVR, 32'h1FF); edges(2);
    chk("R10 dropped", irq_req, 0);
    wr(A_INIT, 2); edges(2); chk("R10 on expiry", irq_req, 1);
    wr(A_SVR, 32'h0FF); chk("R10 gated", irq_req, 0);
    wr(A_SVR, 32'h1FF); chk("R10 kept", irq_req, 1);
    wr(A_EOI, 0); chk("R7 final ack", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_eoi_nonzero();
    t_periodic();
    t_collide();
    t_divide();
    t_zero();
    t_mask();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule